// File: doc/BRIEF.md
# SD Card Command-Line Engine

This block sends one SD/MMC command on the single-bit CMD line and captures the card's reply. Software sets up a command index, a 32-bit argument, a response length (the number of response bits minus one, start bit excluded) and two flags, then pulses `start`. The engine sends the 48-bit command frame with its CRC7 appended. It then releases the line and waits for the card's response start bit. It shifts in the programmed number of response bits and checks their CRC7. It finishes with a one-cycle `done` pulse, a CRC status and a timeout status.

A one-cycle enable strobe `clk_en` paces every CMD-line bit, so one clock domain serves any card clock rate that the strobe divider produces. Captured bits are kept in a response shift register. Software reads it as 32-bit words with the 7 trailing CRC bits dropped, so word 0 holds the payload of a short response. A sticky interrupt flag records each completion until it is acknowledged.

Top module: `sdcmd_engine`

## Requirements
- R1: On the `clk_en` strobes after `start` is accepted, the engine drives 48 bits MSB first with `cmd_oe` high: 0, 1, the 6-bit index, the 32-bit argument, a CRC7 (x^7+x^3+1, register starting at zero, over the first 40 bits), then a stop bit of 1. While `cmd_oe` is low, `cmd_out` is 1.
- R2: `busy` rises the cycle after a `start` accepted while idle and falls on the cycle that `done` pulses. A `start` while busy is ignored: the frame is unchanged and no second completion occurs.
- R3: After the stop bit the line is released and `cmd_in` is sampled on each strobe. The first 0 is the response start bit, and the next `resp_len`+1 bits are captured.
- R4: Without `resp_long`, the CRC7 runs over the start bit and all captured bits except the last 7, and is compared with those last 7. `crc_ok` is 1 only on a match.
- R5: With `resp_long`, the CRC7 starts at the eighth captured bit, so the seven header bits after the start bit are excluded.
- R6: With `resp_nocrc` set, `crc_ok` is 1 whatever the received CRC bits are.
- R7: With `resp_len` = 0, no response is captured. `done` pulses on the first strobe after the stop bit, with `crc_ok`=1 and `timeout`=0.
- R8: If 64 successive samples after the frame are all 1, the command ends with `timeout`=1 and `crc_ok`=0. A start bit on the 64th sample is still accepted.
- R9: `rd_word` is registered one cycle after `rd_sel`. Word w holds captured bits [32w+38:32w+7], counting the last captured bit as bit 0. The register is cleared when a command is accepted.
- R10: `done` lasts one cycle. `irq` is set with `done` and stays set until a cycle with `irq_clr`=1 and no new `done`.
- R11: After reset: `cmd_oe`=0, `cmd_out`=1, and `busy`, `done`, `irq`, `crc_ok`, `timeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | CMD-line bit strobe |
| start | input | 1 | Start pulse |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_len | input | 8 | Response bits minus one; 0 means no response |
| resp_long | input | 1 | CRC7 starts at the eighth captured bit |
| resp_nocrc | input | 1 | Report success whatever the response CRC is |
| cmd_in | input | 1 | Sampled CMD line |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| busy | output | 1 | Engine active |
| done | output | 1 | One-cycle completion pulse |
| crc_ok | output | 1 | Response CRC status of the last command |
| timeout | output | 1 | Last command saw no start bit |
| irq | output | 1 | Sticky completion flag |
| irq_clr | input | 1 | Acknowledge `irq` |
| rd_sel | input | 2 | Response word select |
| rd_word | output | 32 | Selected response word |

## Verification
The bench targets the timeout boundary by placing the card's start bit on the 64th and then the 65th sample. An off-by-one counter would either report a timeout on a good reply or accept a late one. It sends a long response with and without the long-CRC flag: an engine that hashes the header bits fails the good case, and one that skips them regardless passes the bad one. A corrupted CRC is sent with and without the bypass flag, and a mid-command `start` pulse is applied. A design that restarts on that pulse would distort the observed frame or produce a second completion. The response word mapping is read back for short and long replies, which catches a shift offset error.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RECV = 2'd3
  } sdcmd_state_e;

  localparam int            CRC_W     = 7;
  localparam logic [6:0]    CRC_POLY  = 7'h09;  // x^7 + x^3 + 1 (x^7 implicit)
  localparam int            LONG_SKIP = 7;      // header bits excluded in long mode
endpackage

// File: rtl/sdcmd_crc7_step.sv
module sdcmd_crc7_step
  import sdcmd_pkg::*;
(
  input  logic [CRC_W-1:0] crc_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  assign fb    = crc_i[CRC_W-1] ^ bit_i;
  assign crc_o = {crc_i[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
endmodule

// File: rtl/sdcmd_resp_store.sv
module sdcmd_resp_store #(
  parameter int RESP_W = 136,
  parameter int WORD_W = 32,
  parameter int SKIP   = 7,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_i,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word_o
);
  localparam int NWORDS = 1 << SEL_W;

  logic [RESP_W-1:0] sr;
  logic [WORD_W-1:0] words [NWORDS];

  always_ff @(posedge clk) begin
    if (rst || clr)    sr <= '0;
    else if (shift_en) sr <= {sr[RESP_W-2:0], bit_i};
  end

  // Word w skips the trailing CRC bits of the capture.
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign words[w] = sr[w*WORD_W+SKIP +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else     word_o <= words[sel];
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int IDX_W        = 6,
  parameter int ARG_W        = 32,
  parameter int RLEN_W       = 8,
  parameter int RESP_W       = 136,
  parameter int WORD_W       = 32,
  parameter int RD_SEL_W     = 2,
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clk_en,
  input  logic                start,
  input  logic [IDX_W-1:0]    cmd_index,
  input  logic [ARG_W-1:0]    cmd_arg,
  input  logic [RLEN_W-1:0]   resp_len,
  input  logic                resp_long,
  input  logic                resp_nocrc,
  input  logic                cmd_in,
  output logic                cmd_out,
  output logic                cmd_oe,
  output logic                busy,
  output logic                done,
  output logic                crc_ok,
  output logic                timeout,
  output logic                irq,
  input  logic                irq_clr,
  input  logic [RD_SEL_W-1:0] rd_sel,
  output logic [WORD_W-1:0]   rd_word
);
  localparam int PRE_BITS   = 2 + IDX_W + ARG_W;
  localparam int FRAME_BITS = PRE_BITS + CRC_W + 1;
  localparam int TX_CW      = $clog2(FRAME_BITS);
  localparam int TO_W       = $clog2(TIMEOUT_CLKS);
  localparam logic [TX_CW-1:0]  TX_CRC_AT  = TX_CW'(PRE_BITS);
  localparam logic [TX_CW-1:0]  TX_STOP_AT = TX_CW'(PRE_BITS + CRC_W);
  localparam logic [TO_W-1:0]   TO_LAST    = TO_W'(TIMEOUT_CLKS - 1);
  localparam logic [RLEN_W-1:0] SKIP_LONG  = RLEN_W'(LONG_SKIP);

  sdcmd_state_e       st;
  logic [PRE_BITS-1:0] tx_sr;
  logic [TX_CW-1:0]   tx_cnt;
  logic [CRC_W-1:0]   tx_crc, tx_crc_nx;
  logic [CRC_W-1:0]   rx_crc, rx_crc_nx, rx_crc_final;
  logic [RLEN_W-1:0]  rx_cnt;
  logic [TO_W-1:0]    wait_cnt;
  logic [RLEN_W-1:0]  len_q;
  logic               long_q, nocrc_q;
  logic               accept, rx_in_win;
  logic               fin_now, fin_ok, fin_to;

  assign accept = (st == ST_IDLE) && start;

  sdcmd_crc7_step u_tx_crc (.crc_i(tx_crc), .bit_i(tx_sr[PRE_BITS-1]), .crc_o(tx_crc_nx));
  sdcmd_crc7_step u_rx_crc (.crc_i(rx_crc), .bit_i(cmd_in),            .crc_o(rx_crc_nx));

  sdcmd_resp_store #(
    .RESP_W(RESP_W), .WORD_W(WORD_W), .SKIP(CRC_W), .SEL_W(RD_SEL_W)
  ) u_store (
    .clk(clk), .rst(rst), .clr(accept),
    .shift_en(clk_en && (st == ST_RECV)), .bit_i(cmd_in),
    .sel(rd_sel), .word_o(rd_word)
  );

  // Captured bit k (1-based) = rx_cnt+1 is hashed when it lies in the window.
  assign rx_in_win    = rx_cnt >= (long_q ? SKIP_LONG : '0);
  assign rx_crc_final = rx_in_win ? rx_crc_nx : rx_crc;

  always_comb begin
    fin_now = 1'b0;
    fin_ok  = 1'b0;
    fin_to  = 1'b0;
    if (clk_en) begin
      case (st)
        ST_WAIT: begin
          if (len_q == '0) begin
            fin_now = 1'b1;
            fin_ok  = 1'b1;
          end else if (cmd_in && (wait_cnt == TO_LAST)) begin
            fin_now = 1'b1;
            fin_to  = 1'b1;
          end
        end
        ST_RECV: begin
          if (rx_cnt == len_q) begin
            fin_now = 1'b1;
            fin_ok  = nocrc_q || (rx_crc_final == '0);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tx_sr    <= '0;
      tx_cnt   <= '0;
      tx_crc   <= '0;
      rx_crc   <= '0;
      rx_cnt   <= '0;
      wait_cnt <= '0;
      len_q    <= '0;
      long_q   <= 1'b0;
      nocrc_q  <= 1'b0;
      cmd_out  <= 1'b1;
      cmd_oe   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      crc_ok   <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fin_now) begin
        st      <= ST_IDLE;
        busy    <= 1'b0;
        done    <= 1'b1;
        crc_ok  <= fin_ok;
        timeout <= fin_to;
      end
      case (st)
        ST_IDLE: begin
          if (start) begin
            st       <= ST_SEND;
            busy     <= 1'b1;
            tx_sr    <= {2'b01, cmd_index, cmd_arg};
            tx_cnt   <= '0;
            tx_crc   <= '0;
            wait_cnt <= '0;
            len_q    <= resp_len;
            long_q   <= resp_long;
            nocrc_q  <= resp_nocrc;
            crc_ok   <= 1'b0;
            timeout  <= 1'b0;
          end
        end
        ST_SEND: begin
          if (clk_en) begin
            cmd_oe <= 1'b1;
            tx_cnt <= tx_cnt + 1'b1;
            if (tx_cnt < TX_CRC_AT) begin
              cmd_out <= tx_sr[PRE_BITS-1];
              tx_sr   <= {tx_sr[PRE_BITS-2:0], 1'b0};
              tx_crc  <= tx_crc_nx;
            end else if (tx_cnt < TX_STOP_AT) begin
              cmd_out <= tx_crc[CRC_W-1];
              tx_crc  <= {tx_crc[CRC_W-2:0], 1'b0};
            end else begin
              cmd_out <= 1'b1;
              st      <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (clk_en) begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            if (!fin_now) begin
              if (!cmd_in) begin
                st     <= ST_RECV;
                rx_cnt <= '0;
                rx_crc <= '0;
              end else begin
                wait_cnt <= wait_cnt + 1'b1;
              end
            end
          end
        end
        ST_RECV: begin
          if (clk_en) begin
            if (rx_in_win) rx_crc <= rx_crc_nx;
            if (!fin_now)  rx_cnt <= rx_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (fin_now) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end
endmodule

// File: rtl/sdcmd_engine_checker.sv
module sdcmd_engine_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic irq,
  input logic irq_clr,
  input logic crc_ok,
  input logic timeout,
  input logic cmd_out,
  input logic cmd_oe
);
  a_r1_drive_only_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> busy);
  a_r1_released_high: assert property (@(posedge clk) disable iff (rst)
    !cmd_oe |-> cmd_out);
  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r8_timeout_not_ok: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !crc_ok);
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_irq_with_done: assert property (@(posedge clk) disable iff (rst)
    done |-> irq);
  a_r10_irq_clear_only_by_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(irq_clr));
endmodule

bind sdcmd_engine sdcmd_engine_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .irq(irq), .irq_clr(irq_clr), .crc_ok(crc_ok), .timeout(timeout),
  .cmd_out(cmd_out), .cmd_oe(cmd_oe)
);

// File: tb/sdcmd_engine_tb_top.sv
module sdcmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STROBE_DIV = 3;

  typedef struct {
    logic [47:0]  frame;
    bit           ok;
    bit           to;
    bit           chk_words;
    logic [127:0] words;
    string        tag;
  } exp_t;

  logic        clk = 0, rst = 1, clk_en = 0, start = 0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic [7:0]  resp_len = '0;
  logic        resp_long = 0, resp_nocrc = 0, cmd_in = 1, irq_clr = 0;
  logic [1:0]  rd_sel = '0;
  logic        cmd_out, cmd_oe, busy, done, crc_ok, timeout, irq;
  logic [31:0] rd_word;

  int errors = 0, checks = 0, mon_cnt = 0, div_cnt = 0, host_nbits = 0;
  logic [47:0] host_frame = '0;
  bit card_q[$];
  exp_t exp_q[$];

  sdcmd_engine dut_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .start(start),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .resp_len(resp_len),
    .resp_long(resp_long), .resp_nocrc(resp_nocrc), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .done(done),
    .crc_ok(crc_ok), .timeout(timeout), .irq(irq), .irq_clr(irq_clr),
    .rd_sel(rd_sel), .rd_word(rd_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit cond, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [6:0] ref_crc7(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = c[6] ^ v[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // Strobe generator and card model: observe host bits, then play reply.
  always @(negedge clk) begin
    if (clk_en) begin
      if (cmd_oe) begin
        host_frame = {host_frame[46:0], cmd_out};
        host_nbits++;
      end
      if (host_nbits >= 48 && card_q.size() > 0) cmd_in = card_q.pop_front();
      else cmd_in = 1'b1;
    end
    div_cnt = (div_cnt == STROBE_DIV - 1) ? 0 : div_cnt + 1;
    clk_en  = (div_cnt == STROBE_DIV - 1);
  end

  // Monitor: compares every completion against the scoreboard queue.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(host_nbits == 48, {"R1 frame length ", e.tag}, host_nbits, 48);
          check(host_frame == e.frame, {"R1 frame bits ", e.tag}, host_frame, e.frame);
          check(crc_ok == e.ok, {"R4/R5/R6/R7 crc_ok ", e.tag}, crc_ok, e.ok);
          check(timeout == e.to, {"R8 timeout ", e.tag}, timeout, e.to);
          check(irq == 1'b1, {"R10 irq set ", e.tag}, irq, 1);
          if (e.chk_words) begin
            for (int w = 0; w < 4; w++) begin
              rd_sel = 2'(w);
              @(negedge clk);
              if (w == 0) check(done == 1'b0, {"R10 done one cycle ", e.tag}, done, 0);
              check(rd_word == e.words[w*32 +: 32], {"R9 word ", e.tag}, rd_word, e.words[w*32 +: 32]);
            end
          end
        end
        mon_cnt++;
      end
    end
  end

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input int kind,
                       input bit lng, input bit nocrc, input int delay,
                       input logic [119:0] payload, input bit corrupt, input bit poke,
                       input string tag);
    logic [135:0] cap;
    logic [39:0]  body;
    logic [6:0]   c;
    int n, target;
    exp_t e;
    cap = '0; n = 0;
    card_q.delete();
    if (kind == 1) begin
      body = {1'b0, 1'b0, idx, payload[31:0]};
      c = ref_crc7({96'b0, body}, 40);
      if (corrupt) c[0] = ~c[0];
      cap = {97'b0, body[38:0], c};
      n = 46;
    end else if (kind == 2) begin
      c = ref_crc7({16'b0, payload}, 120);
      if (corrupt) c[0] = ~c[0];
      cap = {2'b0, 1'b0, 6'h3F, payload, c};
      n = 134;
    end
    if (kind != 0) begin
      repeat (delay) card_q.push_back(1'b1);
      card_q.push_back(1'b0);
      for (int i = n - 1; i >= 0; i--) card_q.push_back(cap[i]);
      card_q.push_back(1'b1);
    end
    e.frame = {2'b01, idx, arg, ref_crc7({96'b0, 2'b01, idx, arg}, 40), 1'b1};
    e.to    = (kind != 0) && (delay >= 64);
    e.ok    = (kind == 0) ? 1'b1 : (e.to ? 1'b0 : (nocrc || (!corrupt && ((kind == 2) == lng))));
    e.chk_words = (kind != 0) && !e.to;
    for (int w = 0; w < 4; w++) e.words[w*32 +: 32] = cap[w*32+7 +: 32];
    e.tag = tag;
    exp_q.push_back(e);
    host_nbits = 0;
    target = mon_cnt + 1;
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; resp_long = lng; resp_nocrc = nocrc;
    resp_len = (kind == 1) ? 8'd45 : (kind == 2) ? 8'd133 : 8'd0;
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, {"R2 busy after start ", tag}, busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      cmd_index = ~idx; cmd_arg = ~arg; start = 1;
      @(negedge clk);
      start = 0;
    end
    wait (mon_cnt == target);
    if (poke) begin
      repeat (400) @(negedge clk);
      check(mon_cnt == target && busy == 1'b0, {"R2 start while busy ignored ", tag}, mon_cnt, target);
    end
    @(negedge clk);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    check(irq == 1'b0, {"R10 irq cleared ", tag}, irq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(cmd_oe == 0 && cmd_out == 1, "R11 reset line state", {cmd_oe, cmd_out}, 2'b01);
    check({busy, done, irq, crc_ok, timeout} == 5'b0, "R11 reset status",
          {busy, done, irq, crc_ok, timeout}, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    check(busy == 0 && irq == 0, "R11 idle after reset", {busy, irq}, 0);

    issue(6'd17, 32'h1234_5678, 1, 0, 0, 2, 120'h0000_0000_0000_0000_0000_0000_CAFE_F00D, 0, 0, "R3 short basic");
    issue(6'h2A, 32'hFFFF_0000, 1, 0, 0, 0, 120'h0000_0000_0000_0000_0000_0000_A5A5_0F0F, 0, 0, "R4 short pattern");
    issue(6'd13, 32'h0000_0001, 1, 0, 0, 5, 120'h0000_0000_0000_0000_0000_0000_1357_9BDF, 1, 0, "R4 bad crc");
    issue(6'd13, 32'h8000_0000, 1, 0, 1, 5, 120'h0000_0000_0000_0000_0000_0000_1357_9BDF, 1, 0, "R6 crc bypass");
    issue(6'd2,  32'h0,         2, 1, 0, 3, 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, 0, 0, "R5 long ok");
    issue(6'd9,  32'hDEAD_BEEF, 2, 0, 0, 3, 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, 0, 0, "R5 long without flag");
    issue(6'd0,  32'h0,         0, 0, 0, 0, 120'h0, 0, 0, "R7 no response");
    issue(6'd55, 32'h0F0F_F0F0, 1, 0, 0, 63, 120'h0000_0000_0000_0000_0000_0000_8765_4321, 0, 0, "R8 late start accepted");
    issue(6'd55, 32'h0F0F_F0F0, 1, 0, 0, 64, 120'h0000_0000_0000_0000_0000_0000_8765_4321, 0, 0, "R8 timeout");
    issue(6'd7,  32'h5555_AAAA, 1, 0, 0, 1, 120'h0000_0000_0000_0000_0000_0000_0BAD_CAFE, 0, 1, "R2 poke");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule